// File: doc/BRIEF.md
# Protected Reset Pulse Generator

This block drives an external reset pad. When a single-cycle trigger arrives, it asserts the pad for a programmable number of 1 µs ticks. The ticks come in on a strobe input that is high for one clock cycle per microsecond. The pulse lasts the programmed width value plus one tick, so a value of zero still gives a one-tick pulse.

A single 32-bit configuration word sets the pulse. Its low 20 bits hold the width. Two mode bits choose the asserted level and whether the pad is driven push-pull or modelled as open-drain. In open-drain mode a separate output enable is active only during the pulse. The mode bits are guarded: they change only when one of four code bytes is written into bits 31:24. Every write updates the width field, whatever its top byte holds.

A trigger that arrives while a pulse is running is dropped. The width is captured when the pulse starts, so later writes only affect the next pulse. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `rst_pulse_gen`

## Requirements
- R1: After reset the width field is 0xFF and the mode is active-low, open-drain. Readback is 0x0000_00FF and `pad_oe` is 0.
- R2: A trigger accepted while idle starts a pulse on the next clock. The pulse ends on the clock that samples the (W+1)th tick after that, where W is the width captured at the start; W = 0 gives one tick.
- R3: Each write loads `cfg_wdata[19:0]` into the width field. Readback bits 19:0 return it.
- R4: Writing top byte 0xA5 selects active-high and 0x5A selects active-low. Readback bit 31 is 1 for active-high.
- R5: Writing top byte 0xA8 selects push-pull and 0x8A selects open-drain. Readback bit 30 is 1 for push-pull.
- R6: A write whose top byte is none of 0xA5, 0x5A, 0xA8 or 0x8A leaves both mode bits unchanged.
- R7: In push-pull mode `pad_oe` is always 1. `pad_o` carries the asserted level during a pulse and its inverse otherwise.
- R8: In open-drain mode `pad_oe` is 1 only during a pulse, and `pad_o` always carries the asserted level.
- R9: A trigger that arrives while a pulse is running has no effect on that pulse and does not queue a new one.
- R10: A width write during a pulse does not change the length of that pulse.
- R11: Readback bits 29:20 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Readback of width and mode bits |
| tick_1us | input | 1 | One-cycle strobe per microsecond |
| trig | input | 1 | One-cycle pulse request |
| pad_o | output | 1 | Pad data level |
| pad_oe | output | 1 | Pad output enable |

## Verification
Pulses are triggered with a wide width and with width zero, in all four mode combinations. Counting the ticks seen while the pad is asserted separates an off-by-one pulse length from a correct one. Writes with each code byte, and with an unrelated top byte carrying a new width, show that only the intended mode bit moves and that the width always follows. A second trigger and a width write during a running pulse check that the pulse is neither restarted nor resized.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [7:0] CODE_HIGH = 8'hA5;
  localparam logic [7:0] CODE_LOW  = 8'h5A;
  localparam logic [7:0] CODE_PP   = 8'hA8;
  localparam logic [7:0] CODE_OD   = 8'h8A;
  localparam int unsigned HIGH_BIT = 31;
  localparam int unsigned PP_BIT   = 30;

  typedef struct packed {
    logic act_high;
    logic push_pull;
  } mode_t;

  function automatic logic is_code(input logic [7:0] b);
    return (b == CODE_HIGH) || (b == CODE_LOW) || (b == CODE_PP) || (b == CODE_OD);
  endfunction
endpackage

// File: rtl/rpg_rst_sync.sv
module rpg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rpg_cfg_reg.sv
module rpg_cfg_reg
  import rpg_pkg::*;
#(
  parameter int unsigned WB = 20,
  parameter logic [WB-1:0] WIDTH_RST = 'hFF
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WB-1:0]     width_q,
  output mode_t             mode_q,
  output logic [WORD_W-1:0] rd_data
);
  logic [WB-1:0] width_d;
  mode_t         mode_d;
  logic [7:0]    top_b;

  assign top_b = wr_data[WORD_W-1 -: 8];

  always_comb begin
    width_d = width_q;
    mode_d  = mode_q;
    if (wr_en) begin
      width_d = wr_data[WB-1:0];
      case (top_b)
        CODE_HIGH: mode_d.act_high  = 1'b1;
        CODE_LOW:  mode_d.act_high  = 1'b0;
        CODE_PP:   mode_d.push_pull = 1'b1;
        CODE_OD:   mode_d.push_pull = 1'b0;
        default:   mode_d = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q <= WIDTH_RST;
      mode_q  <= '{act_high: 1'b0, push_pull: 1'b0};
    end else if (wr_en) begin
      width_q <= width_d;
      mode_q  <= mode_d;
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[WB-1:0]   = width_q;
    rd_data[HIGH_BIT] = mode_q.act_high;
    rd_data[PP_BIT]   = mode_q.push_pull;
  end

  // R6: a write without a code byte keeps the mode
  p_keep_mode_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !is_code(top_b)) |=> $stable(mode_q));
  // R3: width only moves on a write
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en |=> ($stable(width_q) && $stable(mode_q)));
endmodule

// File: rtl/rpg_pulse_timer.sv
module rpg_pulse_timer #(
  parameter int unsigned WB = 20
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          tick_i,
  input  logic [WB-1:0] width_i,
  output logic          active_o
);
  logic          active_q, active_d;
  logic [WB-1:0] cnt_q, cnt_d;
  logic          last_tick;

  assign last_tick = tick_i && (cnt_q == '0);

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (active_q) begin
      if (last_tick) active_d = 1'b0;
      else if (tick_i) cnt_d = cnt_q - 1'b1;
    end else if (trig_i) begin
      active_d = 1'b1;
      cnt_d    = width_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o = active_q;

  // R2: a pulse only begins after a trigger
  p_start_on_trig_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(active_q) |-> $past(trig_i));
  // R2: a pulse only ends on a tick with the count exhausted
  p_end_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(active_q) |-> ($past(tick_i) && ($past(cnt_q) == '0)));
  // R9: without a tick a running pulse keeps its count, whatever trig does
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (active_q && !tick_i) |=> (active_q && $stable(cnt_q)));
  // R10: the count is captured from the width at start
  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(active_q) |-> (cnt_q == $past(width_i)));
endmodule

// File: rtl/rpg_pad_drive.sv
module rpg_pad_drive
  import rpg_pkg::*;
(
  input  logic  asserted_i,
  input  mode_t mode_i,
  output logic  pad_o,
  output logic  pad_oe
);
  always_comb begin
    if (mode_i.push_pull) begin
      pad_oe = 1'b1;
      pad_o  = asserted_i ? mode_i.act_high : !mode_i.act_high;
    end else begin
      pad_oe = asserted_i;
      pad_o  = mode_i.act_high;
    end
  end
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
  import rpg_pkg::*;
#(
  parameter int unsigned WB = 20,
  parameter logic [WB-1:0] WIDTH_RST = 'hFF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              tick_1us,
  input  logic              trig,
  output logic              pad_o,
  output logic              pad_oe
);
  logic          rst_i_n;
  logic [WB-1:0] width_q;
  mode_t         mode_q;
  logic          active;

  rpg_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  rpg_cfg_reg #(.WB(WB), .WIDTH_RST(WIDTH_RST)) u_cfg (
    .clk(clk), .rst_ni(rst_i_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .width_q(width_q), .mode_q(mode_q), .rd_data(cfg_rdata));

  rpg_pulse_timer #(.WB(WB)) u_tmr (
    .clk(clk), .rst_ni(rst_i_n), .trig_i(trig), .tick_i(tick_1us),
    .width_i(width_q), .active_o(active));

  rpg_pad_drive u_pad (
    .asserted_i(active), .mode_i(mode_q), .pad_o(pad_o), .pad_oe(pad_oe));

  // R8: in open-drain mode the enable follows the pulse from one cycle to the next
  p_od_enable_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!mode_q.push_pull && !active && !trig) |=> (!pad_oe || mode_q.push_pull));
endmodule

// File: tb/test_rst_pulse_gen.sv
module test_rst_pulse_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic tick_1us = 1'b0;
  logic trig = 1'b0;
  logic pad_o, pad_oe;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  rst_pulse_gen i_rst_pulse_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tick_1us(tick_1us), .trig(trig),
    .pad_o(pad_o), .pad_oe(pad_oe));

  // tick strobe: one cycle in four
  logic [1:0] ph = 2'd0;
  always @(negedge clk) begin
    ph <= ph + 2'd1;
    tick_1us <= (ph == 2'd3);
  end

  // behavioural reference
  int unsigned m_width;
  bit m_hi, m_pp, m_active;
  int unsigned m_rem;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_width = 32'hFF; m_hi = 0; m_pp = 0; m_active = 0; m_rem = 0;
    end else begin
      if (m_active) begin
        if (tick_1us) begin
          m_rem = m_rem - 1;
          if (m_rem == 0) m_active = 0;
        end
      end else if (trig) begin
        m_active = 1; m_rem = m_width + 1;
      end
      if (cfg_we) begin
        m_width = cfg_wdata[19:0];
        case (cfg_wdata[31:24])
          8'hA5: m_hi = 1;
          8'h5A: m_hi = 0;
          8'hA8: m_pp = 1;
          8'h8A: m_pp = 0;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference (R7, R8, R3, R11)
  bit cmp_en = 0;
  always @(posedge clk) begin
    #3;
    if (cmp_en) begin
      check("R3_R11 rdata model", cfg_rdata, {m_hi, m_pp, 10'b0, m_width[19:0]});
      check("R7_R8 pad_oe model", {31'b0, pad_oe}, {31'b0, (m_pp ? 1'b1 : m_active)});
      check("R7_R8 pad_o model", {31'b0, pad_o},
            {31'b0, (m_pp ? (m_active ? m_hi : !m_hi) : m_hi)});
    end
  end

  // tick counter while pad asserted
  int tick_seen = 0;
  always @(posedge clk) begin
    if (tick_1us && pad_oe && (pad_o == m_hi)) tick_seen++;
  end

  function automatic bit asserted();
    return pad_oe && (pad_o == m_hi);
  endfunction

  task automatic wr(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!asserted()) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cmp_en = 1;
    // R1 reset state
    check("R1 rdata", cfg_rdata, 32'h0000_00FF);
    check("R1 pad_oe", {31'b0, pad_oe}, 32'd0);

    // R4 / R3
    wr(32'hA500_0003);
    check("R4 R3 high code", cfg_rdata, 32'h8000_0003);
    // R6 / R11: unrelated top byte
    wr(32'h1234_5007);
    check("R6 R11 no code", cfg_rdata, 32'h8004_5007);
    // R5
    wr(32'hA800_0002);
    check("R5 pp code", cfg_rdata, 32'hC000_0002);
    check("R7 idle level", {30'b0, pad_oe, pad_o}, 32'h2);

    // R2 with width 2, plus R9 and R10 during the pulse
    tick_seen = 0;
    fire();
    check("R7 asserted level", {30'b0, pad_oe, pad_o}, 32'h3);
    repeat (2) @(negedge clk);
    fire();
    wr(32'h0000_0009);
    wait_done();
    check("R2 R9 R10 tick count", tick_seen, 32'd3);
    check("R10 width stored", cfg_rdata, 32'hC000_0009);

    // open-drain, active-low, width 0
    wr(32'h5A00_0000);
    wr(32'h8A00_0000);
    check("R4 R5 low od codes", cfg_rdata, 32'h0000_0000);
    check("R8 idle oe", {30'b0, pad_oe, pad_o}, 32'h0);
    tick_seen = 0;
    fire();
    check("R8 pulse oe", {30'b0, pad_oe, pad_o}, 32'h2);
    wait_done();
    check("R2 width zero", tick_seen, 32'd1);
    check("R8 after pulse", {30'b0, pad_oe, pad_o}, 32'h0);

    // open-drain active-high, width 5
    wr(32'hA500_0005);
    check("R8 idle level high", {30'b0, pad_oe, pad_o}, 32'h1);
    tick_seen = 0;
    fire();
    wait_done();
    check("R2 width five", tick_seen, 32'd6);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule